// File: doc/BRIEF.md
# FM Synthesizer Interval Timer Pair

This block keeps the two interval timers and the status byte of an FM sound synthesizer. A clock-enable input, `tick_en`, pulses once per internal sub-cycle of the synthesizer. A shared prescaler divides these pulses into a fast step for the first timer. A further divide-by-`B_DIV` stage gives a slower step for the second timer. Each timer counts down from a reload value and raises a status flag when it wraps, if the flag is enabled. The interrupt line is the OR of the two flags.

Software loads the timers and controls them through a single register write strobe with a 2-bit register select. Every register write also sets a busy bit in the status byte. The busy bit then stays set for a fixed number of tick pulses. The sound-generation datapath is not part of this block.

Top module: `fm_interval_timers`

## Requirements
- R1: After reset, `status` reads 0 and `irq` is low. Both counts, both reload values and the control register are 0.
- R2: Register select encoding: 0 = timer A high, 1 = timer A low, 2 = timer B reload, 3 = control. A high write stores `wr_data[7:0]` into reload A bits [9:2]. A low write stores only `wr_data[1:0]` into bits [1:0], and the other data bits are ignored.
- R3: Timer A steps on the first tick pulse of every `A_PERIOD` tick pulses. With a reload value L, its flag is set every (L+1)*`A_PERIOD` tick pulses.
- R4: Timer B takes all 8 bits of its reload register. It steps only on every `B_DIV`-th timer A step boundary, always in the same cycle as one of them. Its flag is set every (L+1)*`A_PERIOD`*`B_DIV` tick pulses.
- R5: On a step, an enabled timer with a nonzero count decrements. With a zero count, it reloads from its reload value and sets its flag (status bit 0 for A, bit 1 for B) if its overflow-flag enable is set.
- R6: Control bit 0 enables timer A and bit 1 enables timer B. A disabled timer holds its count and never sets its flag.
- R7: Control bit 2 (A) and bit 3 (B) are the overflow-flag enables. With an enable clear, the timer still runs but its flag is not set.
- R8: Writing control with bit 4 (A) or bit 5 (B) set clears that flag. A flag stays set until it is cleared this way, even if its timer is disabled.
- R9: `irq` is high exactly when status bit 0 or status bit 1 is set.
- R10: Writing a reload register does not change a running count. The new value takes effect at the next reload.
- R11: Status bit 7 (busy) is set on the clock after any register write. It clears once `BUSY_TICKS` tick pulses have followed that write. Without tick pulses, it stays set.
- R12: Status bits 6 to 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One pulse per synthesizer sub-cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 A high, 1 A low, 2 B reload, 3 control) |
| wr_data | input | 8 | Write data |
| status | output | 8 | {busy, 5'b0, flag B, flag A} |
| irq | output | 1 | Timer interrupt, OR of the two flags |

## Verification
A wrong count or a skewed prescaler phase cannot be seen directly. It shows up only as a wrong interval between two consecutive flag rises, so the bench measures that interval in clock cycles, and the error is visible one full timer period later. A divider fault in timer B surfaces only after B_DIV timer A periods. A busy counter that counts clocks instead of tick pulses shows up as soon as tick pulses are withheld after a write.

// File: rtl/fm_tmr_pkg.sv
package fm_tmr_pkg;

   typedef enum logic [1:0] {
      SEL_A_HI   = 2'd0,
      SEL_A_LO   = 2'd1,
      SEL_B_LOAD = 2'd2,
      SEL_CTRL   = 2'd3
   } tmr_sel_e;

   localparam int CTL_EN_A  = 0;
   localparam int CTL_EN_B  = 1;
   localparam int CTL_OVF_A = 2;
   localparam int CTL_OVF_B = 3;
   localparam int CTL_CLR_A = 4;
   localparam int CTL_CLR_B = 5;

   typedef struct packed {
      logic ovf_b;
      logic ovf_a;
      logic en_b;
      logic en_a;
   } tmr_ctrl_t;

endpackage

// File: rtl/fm_tmr_prescale.sv
module fm_tmr_prescale #(
   parameter int A_PERIOD = 144,
   parameter int B_DIV    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   output logic step_a,
   output logic step_b
);
   localparam int PW = $clog2(A_PERIOD);

   if (A_PERIOD < 2) begin : g_bad_period
      $error("fm_tmr_prescale: A_PERIOD must be at least 2");
   end
   if (B_DIV < 1) begin : g_bad_div
      $error("fm_tmr_prescale: B_DIV must be at least 1");
   end

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (tick_en) begin
         pre_q <= (pre_q == PW'(A_PERIOD - 1)) ? '0 : pre_q + 1'b1;
      end
   end

   assign step_a = tick_en && (pre_q == '0);

   if (B_DIV == 1) begin : g_no_div
      assign step_b = step_a;
   end else begin : g_div
      localparam int DW = $clog2(B_DIV);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (step_a) begin
            div_q <= (div_q == DW'(B_DIV - 1)) ? '0 : div_q + 1'b1;
         end
      end

      assign step_b = step_a && (div_q == '0);
   end

endmodule

// File: rtl/fm_tmr_down.sv
module fm_tmr_down #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         enable,
   input  logic         ovf_en,
   input  logic         clr,
   input  logic [W-1:0] load,
   output logic         flag
);
   if (W < 1) begin : g_bad_w
      $error("fm_tmr_down: W must be positive");
   end

   logic [W-1:0] cnt_q;
   logic         adv;
   logic         wrap;

   assign adv  = step && enable;
   assign wrap = adv && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= wrap ? load : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (wrap && ovf_en) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/fm_tmr_busy.sv
module fm_tmr_busy #(
   parameter int TICKS = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic tick,
   output logic busy
);
   localparam int BW = $clog2(TICKS + 1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("fm_tmr_busy: TICKS must be positive");
   end

   logic [BW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (wr) begin
         left_q <= BW'(TICKS);
      end else if (tick && (left_q != '0)) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy = (left_q != '0);

endmodule

// File: rtl/fm_interval_timers.sv
module fm_interval_timers
   import fm_tmr_pkg::*;
#(
   parameter int A_W        = 10,
   parameter int B_W        = 8,
   parameter int A_PERIOD   = 144,
   parameter int B_DIV      = 16,
   parameter int BUSY_TICKS = 17
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       wr_en,
   input  logic [1:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] status,
   output logic       irq
);
   localparam int A_LO = A_W - 8;

   if (A_W < 9 || A_W > 16) begin : g_bad_aw
      $error("fm_interval_timers: A_W must be 9..16");
   end
   if (B_W < 1 || B_W > 8) begin : g_bad_bw
      $error("fm_interval_timers: B_W must be 1..8");
   end

   tmr_sel_e     sel;
   tmr_ctrl_t    ctrl_q;
   logic [A_W-1:0] load_a_q;
   logic [B_W-1:0] load_b_q;
   logic         step_a, step_b;
   logic         flag_a, flag_b, busy;
   logic         ctl_wr, clr_a, clr_b;

   assign sel    = tmr_sel_e'(wr_sel);
   assign ctl_wr = wr_en && (sel == SEL_CTRL);
   assign clr_a  = ctl_wr && wr_data[CTL_CLR_A];
   assign clr_b  = ctl_wr && wr_data[CTL_CLR_B];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_a_q <= '0;
         load_b_q <= '0;
         ctrl_q   <= '0;
      end else if (wr_en) begin
         unique case (sel)
            SEL_A_HI:   load_a_q[A_W-1:A_LO] <= wr_data;
            SEL_A_LO:   load_a_q[A_LO-1:0]   <= wr_data[A_LO-1:0];
            SEL_B_LOAD: load_b_q             <= wr_data[B_W-1:0];
            SEL_CTRL: begin
               ctrl_q.en_a  <= wr_data[CTL_EN_A];
               ctrl_q.en_b  <= wr_data[CTL_EN_B];
               ctrl_q.ovf_a <= wr_data[CTL_OVF_A];
               ctrl_q.ovf_b <= wr_data[CTL_OVF_B];
            end
            default: ;
         endcase
      end
   end

   fm_tmr_prescale #(.A_PERIOD(A_PERIOD), .B_DIV(B_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .step_a(step_a), .step_b(step_b)
   );

   fm_tmr_down #(.W(A_W)) u_tmr_a (
      .clk(clk), .rst_n(rst_n), .step(step_a), .enable(ctrl_q.en_a),
      .ovf_en(ctrl_q.ovf_a), .clr(clr_a), .load(load_a_q), .flag(flag_a)
   );

   fm_tmr_down #(.W(B_W)) u_tmr_b (
      .clk(clk), .rst_n(rst_n), .step(step_b), .enable(ctrl_q.en_b),
      .ovf_en(ctrl_q.ovf_b), .clr(clr_b), .load(load_b_q), .flag(flag_b)
   );

   fm_tmr_busy #(.TICKS(BUSY_TICKS)) u_busy (
      .clk(clk), .rst_n(rst_n), .wr(wr_en), .tick(tick_en), .busy(busy)
   );

   assign status = {busy, 5'b0, flag_b, flag_a};
   assign irq    = flag_a | flag_b;

endmodule

// File: rtl/fm_interval_timers_chk.sv
module fm_interval_timers_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_en,
   input logic       wr_en,
   input logic [1:0] wr_sel,
   input logic [1:0] clr_bits,
   input logic [7:0] status,
   input logic       irq,
   input logic       step_a,
   input logic       step_b,
   input logic [3:0] ctrl
);
   AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> status[7]); // R11
   AST_BUSY_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && !tick_en) |=> status[7]); // R11
   AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      step_a |-> tick_en); // R3
   AST_B_STEP_WITH_A: assert property (@(posedge clk) disable iff (!rst_n)
      step_b |-> step_a); // R4
   AST_A_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $past(step_a && ctrl[0] && ctrl[2])); // R5
   AST_B_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> $past(step_b && ctrl[1] && ctrl[3])); // R6
   AST_CLEAR_A: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && clr_bits[0] && !step_a) |=> !status[0]); // R8
   AST_CLEAR_B: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && clr_bits[1] && !step_b) |=> !status[1]); // R8
   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($rose(status[0]) || $rose(status[1]))); // R9
endmodule

bind fm_interval_timers fm_interval_timers_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
   .wr_sel(wr_sel), .clr_bits(wr_data[5:4]), .status(status), .irq(irq),
   .step_a(step_a), .step_b(step_b), .ctrl(ctrl_q)
);

// File: tb/fm_interval_timers_tb.sv
module fm_interval_timers_tb;
   localparam int AP  = 6;
   localparam int BD  = 16;
   localparam int BSY = 17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] status;
   logic       irq;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   fm_interval_timers #(.A_PERIOD(AP), .B_DIV(BD), .BUSY_TICKS(BSY)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .status(status), .irq(irq)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         checks = checks + 1;
         failures = failures + 1;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_rise(input int b, output int t);
      while (status[b] !== 1'b1) @(negedge clk);
      t = cyc;
   endtask

   // R2 R3 R5: flag interval of timer A from split reload bytes
   task automatic measure_a(input logic [7:0] hi, input logic [7:0] lo, input string req);
      int t1, t2, l;
      l = int'(hi) * 4 + int'(lo & 8'h03);
      wr(2'd0, hi);
      wr(2'd1, lo);
      wr(2'd3, 8'h15);
      wait_rise(0, t1);
      wr(2'd3, 8'h15);
      wait_rise(0, t2);
      wr(2'd3, 8'h15);
      chk((t2 - t1) == (l + 1) * AP, req, t2 - t1, (l + 1) * AP);
   endtask

   // R4: flag interval of timer B
   task automatic measure_b(input int l);
      int t1, t2;
      wr(2'd2, 8'(l));
      wr(2'd3, 8'h2A);
      wait_rise(1, t1);
      wr(2'd3, 8'h2A);
      wait_rise(1, t2);
      wr(2'd3, 8'h2A);
      chk((t2 - t1) == (l + 1) * AP * BD, "R4 timer B interval", t2 - t1, (l + 1) * AP * BD);
   endtask

   initial begin
      int n, t1, t2, t3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status == 8'h00, "R1 reset status", status, 0);
      chk(irq == 1'b0, "R1 reset irq", irq, 0);

      // R11: busy holds without ticks, clears after BSY ticks
      wr(2'd3, 8'h00);
      chk(status[7] == 1'b1, "R11 busy set after write", status[7], 1);
      repeat (50) @(negedge clk);
      chk(status[7] == 1'b1, "R11 busy held without ticks", status[7], 1);
      tick_en = 1'b1;
      n = 0;
      while (status[7] && n < 1000) begin @(negedge clk); n++; end
      chk(n == BSY, "R11 busy ticks (gated start)", n, BSY);
      wr(2'd3, 8'h00);
      n = 0;
      while (status[7] && n < 1000) begin @(negedge clk); n++; end
      chk(n == BSY, "R11 busy ticks (free ticks)", n, BSY);

      measure_a(8'h00, 8'h00, "R3 timer A interval L=0");
      measure_a(8'h00, 8'h01, "R3 timer A interval L=1");
      measure_a(8'h00, 8'h02, "R5 timer A interval L=2");
      measure_a(8'h01, 8'h03, "R3 timer A interval L=7");
      measure_a(8'h55, 8'hFE, "R2 timer A split reload 0x156");
      measure_a(8'hFF, 8'hFF, "R2 timer A max reload 0x3FF");

      measure_b(0);
      measure_b(1);
      measure_b(4);
      measure_b(100);

      // R10: reload change during a run affects only the next reload
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h01);
      wr(2'd3, 8'h15);
      wait_rise(0, t1);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h03);
      wr(2'd3, 8'h15);
      wait_rise(0, t2);
      wr(2'd3, 8'h15);
      wait_rise(0, t3);
      wr(2'd3, 8'h15);
      chk((t2 - t1) == 10 * AP, "R10 running count kept", t2 - t1, 10 * AP);
      chk((t3 - t2) == 4 * AP, "R10 new reload used next", t3 - t2, 4 * AP);

      // R7: enabled, overflow flag disabled
      wr(2'd3, 8'h11);
      repeat (100) @(negedge clk);
      chk(status[0] == 1'b0, "R7 no flag without overflow enable", status[0], 0);

      // R6: overflow enables on, timers disabled
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h3C);
      repeat (400) @(negedge clk);
      chk(status[1:0] == 2'b00, "R6 disabled timers raise nothing", status[1:0], 0);

      // R8 R9
      wr(2'd3, 8'h35);
      wait_rise(0, t1);
      chk(irq == 1'b1, "R9 irq from flag A", irq, 1);
      chk(status[1] == 1'b0, "R9 flag B stays clear", status[1], 0);
      wr(2'd3, 8'h00);
      repeat (30) @(negedge clk);
      chk(status[0] == 1'b1, "R8 flag persists while disabled", status[0], 1);
      wr(2'd3, 8'h30);
      chk(status[0] == 1'b0, "R8 flag A cleared by control write", status[0], 0);
      chk(irq == 1'b0, "R9 irq low with no flags", irq, 0);
      wr(2'd3, 8'h2A);
      wait_rise(1, t1);
      chk(irq == 1'b1 && status[0] == 1'b0, "R9 irq from flag B only", irq, 1);
      chk(status[6:2] == 5'b0, "R12 unused status bits", status[6:2], 0);
      wr(2'd3, 8'h20);
      chk(status[1] == 1'b0, "R8 flag B cleared by control write", status[1], 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule